// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block collects single-cycle event pulses and two level signals from the surrounding peripherals and holds each occurrence in a sticky flag bit. A byte-wide register port gives software read and write access to a control register and a flag register. Two interrupt lines go to the processor. `nmi_o` cannot be masked and is shared by the data-ready and battery-fail flags. `irq_o` is the OR of four flags, and each of those four flags has its own mask bit.

Flags are recorded whether or not their source is masked, so software can poll masked sources. The battery-fail pin and the out-of-range level are first brought into the clock domain through a two-flop synchronizer, and their edges are detected after that. Software clears a flag by writing the flag register with a zero in that bit. If hardware sets a flag in the same cycle, the hardware set wins.

The block has no state machine. Its behaviour is held in two registers, the control register and the flag register, and in the stages of the two synchronizers. It changes state on two kinds of transition: a hardware set, which ORs new bits into the flags, and a bus write, which loads a register.

Top module: `intr_flag_ctl`

## Requirements
- R1: After reset the control register reads 0x0F, the flag register reads 0x00, and `nmi_o` and `irq_o` are low.
- R2: When `bus_sel`=0, `bus_rdata` shows the control register: bit0 timer-0 mask, bit1 timer-1 mask, bit2 RTC mask, bit3 out-of-range mask, bit4 RTC enable, bits 7:5 read 0. When `bus_sel`=1, it shows the flag register: bit0 timer-0, bit1 timer-1, bit2 out-of-range, bit3 watchdog, bit4 battery-fail, bit5 data-ready, bit6 RTC, bit7 reads 0.
- R3: A write (`bus_we`=1) loads the selected register from `bus_wdata`. The new value is visible after the clock edge. A 1 written to a flag bit sets it and a 0 clears it.
- R4: A pulse on any one of `call_end_i`, `buf_full_i` or `batch_end_i` sets the data-ready flag (bit5) at the next clock edge.
- R5: A high-to-low transition on `batt_pin_i` sets the battery-fail flag (bit4) at the third clock edge after the change. A low-to-high transition sets nothing.
- R6: A change of `oor_level_i` in either direction sets the out-of-range flag (bit2) at the third clock edge after the change.
- R7: Pulses on `tmr0_ovf_i`, `tmr1_ovf_i`, `wdt_ovf_i` and `rtc_tmo_i` set flag bits 0, 1, 3 and 6 at the next edge, whatever the mask bits hold.
- R8: `nmi_o` is high exactly while the data-ready flag or the battery-fail flag is set. No mask bit affects it.
- R9: `irq_o` is high exactly while at least one of flags 0, 1, 2 and 6 is set and its own mask bit is 0. The watchdog flag never drives `irq_o`.
- R10: If a hardware set and a bus write of 0 hit the same flag in the same cycle, the flag is 1 after the edge.
- R11: `rtc_en_o` follows control bit4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select: 0 control, 1 flags |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| call_end_i | input | 1 | Pulse: call finished |
| buf_full_i | input | 1 | Pulse: message buffer full |
| batch_end_i | input | 1 | Pulse: batch over, message still open |
| batt_pin_i | input | 1 | Asynchronous battery-fail pin, idle high |
| oor_level_i | input | 1 | Asynchronous out-of-range status level |
| tmr0_ovf_i | input | 1 | Pulse: timer 0 overflow |
| tmr1_ovf_i | input | 1 | Pulse: timer 1 overflow |
| rtc_tmo_i | input | 1 | Pulse: RTC timeout |
| wdt_ovf_i | input | 1 | Pulse: watchdog overflow |
| nmi_o | output | 1 | Non-maskable interrupt |
| irq_o | output | 1 | Maskable interrupt request |
| rtc_en_o | output | 1 | RTC enable bit |

## Verification
Two functions can fall in the same cycle: a hardware event setting a flag, and a software write loading the flag register. The bench first sets a flag. It then raises that flag's event pulse in the same cycle as a bus write of 0x00 to the flag register. After the edge it reads back the flag register and expects the raced bit to be 1 and every other bit to be 0. The bench repeats this for a timer source and for the data-ready source, so that both output lines are covered. Around this case, near-exhaustive sweeps pair every mask value with every IRQ flag pattern, and every flag value with a readback, and compute the expected outputs arithmetically.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int DATA_W  = 8;
    localparam int FLAG_N  = 7;
    localparam int CTRL_N  = 5;
    // flag bit positions
    localparam int F_TM0 = 0;
    localparam int F_TM1 = 1;
    localparam int F_OOR = 2;
    localparam int F_WDT = 3;
    localparam int F_BAT = 4;
    localparam int F_DRY = 5;
    localparam int F_RTC = 6;
    // control bit positions
    localparam int C_MTM0 = 0;
    localparam int C_MTM1 = 1;
    localparam int C_MRTC = 2;
    localparam int C_MOOR = 3;
    localparam int C_RTCE = 4;
    localparam logic [CTRL_N-1:0] CTRL_RST = 5'b01111;

    typedef enum logic {SEL_CTRL = 1'b0, SEL_FLAG = 1'b1} reg_sel_e;
endpackage

// File: rtl/intr_edge_sync.sv
module intr_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            last  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], async_i};
            last  <= chain[STAGES-1];
        end
    end

    always_comb begin
        rise_o =  chain[STAGES-1] & ~last;
        fall_o = ~chain[STAGES-1] &  last;
    end

    // R5
    fall_only_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(chain[STAGES-1]));
endmodule

// File: rtl/intr_sticky_reg.sv
module intr_sticky_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[b] <= 1'b0;
            else if (set_i[b])
                q[b] <= 1'b1;
            else if (wr_en)
                q[b] <= wr_val[b];
        end

        // R10
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> q[b]);
        // R3
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[b] && !wr_en) |=> $stable(q[b]));
    end
endmodule

// File: rtl/intr_flag_ctl.sv
module intr_flag_ctl
    import intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              call_end_i,
    input  logic              buf_full_i,
    input  logic              batch_end_i,
    input  logic              batt_pin_i,
    input  logic              oor_level_i,
    input  logic              tmr0_ovf_i,
    input  logic              tmr1_ovf_i,
    input  logic              rtc_tmo_i,
    input  logic              wdt_ovf_i,
    output logic              nmi_o,
    output logic              irq_o,
    output logic              rtc_en_o
);
    logic [CTRL_N-1:0] ctrl_q;
    logic [FLAG_N-1:0] flag_q;
    logic [FLAG_N-1:0] set_vec;
    logic              bat_rise, bat_fall, oor_rise, oor_fall;
    logic              flag_wr;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(bus_sel);

    intr_edge_sync #(.STAGES(2), .RST_VAL(1'b1)) i_bat_sync (
        .clk(clk), .rst_n(rst_n), .async_i(batt_pin_i),
        .rise_o(bat_rise), .fall_o(bat_fall));

    intr_edge_sync #(.STAGES(2), .RST_VAL(1'b0)) i_oor_sync (
        .clk(clk), .rst_n(rst_n), .async_i(oor_level_i),
        .rise_o(oor_rise), .fall_o(oor_fall));

    always_comb begin
        set_vec        = '0;
        set_vec[F_TM0] = tmr0_ovf_i;
        set_vec[F_TM1] = tmr1_ovf_i;
        set_vec[F_OOR] = oor_rise | oor_fall;
        set_vec[F_WDT] = wdt_ovf_i;
        set_vec[F_BAT] = bat_fall;
        set_vec[F_DRY] = call_end_i | buf_full_i | batch_end_i;
        set_vec[F_RTC] = rtc_tmo_i;
    end

    assign flag_wr = bus_we && (sel == SEL_FLAG);

    intr_sticky_reg #(.W(FLAG_N)) i_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(flag_wr),
        .wr_val(bus_wdata[FLAG_N-1:0]), .set_i(set_vec), .q(flag_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (bus_we && sel == SEL_CTRL)
            ctrl_q <= bus_wdata[CTRL_N-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL: bus_rdata[CTRL_N-1:0] = ctrl_q;
            SEL_FLAG: bus_rdata[FLAG_N-1:0] = flag_q;
        endcase
    end

    always_comb begin
        nmi_o = flag_q[F_DRY] | flag_q[F_BAT];
        irq_o = (flag_q[F_TM0] & ~ctrl_q[C_MTM0]) |
                (flag_q[F_TM1] & ~ctrl_q[C_MTM1]) |
                (flag_q[F_OOR] & ~ctrl_q[C_MOOR]) |
                (flag_q[F_RTC] & ~ctrl_q[C_MRTC]);
        rtc_en_o = ctrl_q[C_RTCE];
    end

    // R9
    irq_needs_open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctrl_q[C_MOOR:C_MTM0] != 4'hF));
    // R8
    nmi_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(set_vec[F_DRY] || set_vec[F_BAT] || flag_wr));
    // R4
    dry_event_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_end_i || buf_full_i || batch_end_i) |=> nmi_o);
endmodule

// File: tb/test_intr_flag_ctl.sv
module test_intr_flag_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       call_end_i = 0, buf_full_i = 0, batch_end_i = 0;
    logic       batt_pin_i = 1, oor_level_i = 0;
    logic       tmr0_ovf_i = 0, tmr1_ovf_i = 0, rtc_tmo_i = 0, wdt_ovf_i = 0;
    logic       nmi_o, irq_o, rtc_en_o;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    intr_flag_ctl i_intr_flag_ctl (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        bus_sel = sel; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        bus_sel = sel; #1; d = bus_rdata;
    endtask

    function automatic logic exp_irq(input logic [7:0] f, input logic [7:0] c);
        return (f[0] & ~c[0]) | (f[1] & ~c[1]) | (f[2] & ~c[3]) | (f[6] & ~c[2]);
    endfunction

    task automatic cycle();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 8'h0F);
        rd(1, v); chk("R1 flags", v, 8'h00);
        chk("R1 nmi/irq", {nmi_o, irq_o}, 2'b00);
        rst_n = 1'b1;
        cycle();
        rd(0, v); chk("R1 ctrl after release", v, 8'h0F);

        // R2/R3/R8 flag sweep with all masks open
        wr(0, 8'h00);
        for (int f = 0; f < 256; f++) begin
            wr(1, f[7:0]);
            rd(1, v); chk("R3 flag readback", v, f[7:0] & 8'h7F);
            chk("R8 nmi", {7'd0, nmi_o}, {7'd0, f[5] | f[4]});
            chk("R9 irq open", {7'd0, irq_o}, {7'd0, exp_irq(f[7:0], 8'h00)});
        end
        // R2/R9/R11 mask x flag sweep
        for (int c = 0; c < 32; c++) begin
            wr(0, {3'b111, c[4:0]});
            rd(0, v); chk("R2 ctrl readback", v, {3'b000, c[4:0]});
            chk("R11 rtc_en", {7'd0, rtc_en_o}, {7'd0, c[4]});
            for (int p = 0; p < 16; p++) begin
                logic [7:0] fv;
                fv = {1'b0, p[3], 1'b0, 1'b1, 1'b1, p[2], p[1], p[0]};
                wr(1, fv);
                chk("R9 irq masked", {7'd0, irq_o}, {7'd0, exp_irq(fv, {3'b0, c[4:0]})});
                chk("R8 nmi unmaskable", {7'd0, nmi_o}, 8'd1);
            end
        end

        // R7 sources set flags while fully masked
        wr(0, 8'h0F); wr(1, 8'h00);
        tmr0_ovf_i = 1; tmr1_ovf_i = 1; wdt_ovf_i = 1; rtc_tmo_i = 1;
        cycle();
        tmr0_ovf_i = 0; tmr1_ovf_i = 0; wdt_ovf_i = 0; rtc_tmo_i = 0;
        rd(1, v); chk("R7 masked sets", v, 8'h4B);
        chk("R7 irq stays low", {7'd0, irq_o}, 8'd0);

        // R4 each data-ready cause
        for (int k = 0; k < 3; k++) begin
            wr(1, 8'h00);
            call_end_i = (k == 0); buf_full_i = (k == 1); batch_end_i = (k == 2);
            cycle();
            call_end_i = 0; buf_full_i = 0; batch_end_i = 0;
            rd(1, v); chk("R4 data-ready", v, 8'h20);
            chk("R8 nmi on dry", {7'd0, nmi_o}, 8'd1);
        end

        // R5 battery pin edges
        wr(1, 8'h00);
        batt_pin_i = 0;
        cycle(); cycle();
        rd(1, v); chk("R5 not yet", v, 8'h00);
        cycle();
        rd(1, v); chk("R5 fall sets", v, 8'h10);
        wr(1, 8'h00);
        batt_pin_i = 1;
        repeat (5) cycle();
        rd(1, v); chk("R5 rise ignored", v, 8'h00);
        chk("R5 nmi low", {7'd0, nmi_o}, 8'd0);

        // R6 out-of-range both directions, unmasked
        wr(0, 8'h00);
        oor_level_i = 1;
        cycle(); cycle();
        rd(1, v); chk("R6 not yet", v, 8'h00);
        cycle();
        rd(1, v); chk("R6 rise sets", v, 8'h04);
        chk("R6 irq", {7'd0, irq_o}, 8'd1);
        wr(1, 8'h00);
        oor_level_i = 0;
        repeat (3) cycle();
        rd(1, v); chk("R6 fall sets", v, 8'h04);

        // R10 set beats same-cycle clear
        wr(1, 8'h01);
        bus_sel = 1; bus_we = 1; bus_wdata = 8'h00; tmr0_ovf_i = 1;
        cycle();
        bus_we = 0; tmr0_ovf_i = 0;
        rd(1, v); chk("R10 timer set wins", v, 8'h01);
        wr(1, 8'h20);
        bus_sel = 1; bus_we = 1; bus_wdata = 8'h00; call_end_i = 1;
        cycle();
        bus_we = 0; call_end_i = 0;
        rd(1, v); chk("R10 dry set wins", v, 8'h20);
        chk("R10 nmi", {7'd0, nmi_o}, 8'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule